// File: doc/BRIEF.md
# Ping-Pong Buffered Card Bus Clock Flow Controller

This block connects a processor-side byte port to a bit-serial memory-card data line. Two 8-byte buffers are used in strict alternation. While the processor fills or empties one, the serial side works on the other. The block drives a bus clock enable, where each enabled cycle moves one bit, and it can stop that clock based on the joint state of the two buffers. A processor running at any speed then never causes the serial side to overrun or underrun. The bus stays frozen while the clock is stopped, and it resumes by itself once processor accesses have freed or filled a buffer.

A direction input selects transmit or receive. The clock runs only while the transfer enable is set. Stop and restart decisions are taken only between bytes, so a byte is never split across a pause. Each buffer has a full flag and an empty flag. Each flag has its own mask bit, and the unmasked flags are ORed into a single interrupt line.

Both processor-side data paths use valid/ready. In transmit, `cpu_wr_ready` is high while the buffer due to be written next is not full, and a byte is taken on a cycle where valid and ready are both high. In receive, `cpu_rd_valid` is high while the buffer due to be read next is full. `cpu_rd_data` then holds steady until `cpu_rd_ready` accepts it. The processor may hold valid or ready as long as it likes, and no byte is lost or duplicated.

Top module: `card_flow_ctrl`

## Requirements
- R1: After reset, both empty flags are 1, both full flags are 0, every mask bit is 1, `irq` is 0, `cpu_wr_ready` is 1, `cpu_rd_valid` is 0, and `bus_clk_en` is 0 while `cfg_xfer_en` is 0.
- R2: In transmit (`cfg_rx`=0), each enabled clock cycle puts one bit on `bus_dout`, most significant bit first. Bytes leave in the order written, with buffer 0 first after reset and the buffers alternating every 8 bytes.
- R3: In transmit with `cfg_flow_en`=1, `bus_clk_en` is 0 at a byte boundary when both empty flags are set. While `bus_clk_en` is 0, `bus_dout` keeps its value.
- R4: In transmit with flow control, the clock restarts in the cycle after the processor completes the 8th write to a buffer. Seven writes are not enough to restart it.
- R5: In receive (`cfg_rx`=1), `bus_din` is sampled on each enabled cycle, most significant bit first. The processor reads the bytes in arrival order through the alternating buffers.
- R6: In receive with flow control, `bus_clk_en` is 0 at a byte boundary when both full flags are set.
- R7: In receive with flow control, the clock restarts in the cycle after the processor completes the 8th read of a full buffer. Seven reads are not enough to restart it.
- R8: With `cfg_flow_en`=0, the clock runs at byte boundaries whenever `cfg_xfer_en`=1. A transmit byte slot with no full buffer sends 0xFF and consumes nothing.
- R9: Once a byte has started, `bus_clk_en` stays 1 until all 8 of its bits have moved, even if `cfg_xfer_en` drops. The number of enabled cycles in a transfer is therefore a multiple of 8.
- R10: The mask word is written through `msk_we`/`msk_wdata`. Bit 0 masks full flag 0, bit 1 masks full flag 1, bit 2 masks empty flag 0 and bit 3 masks empty flag 1; a 1 masks. `irq` is the OR of the set flags whose mask bit is 0.
- R11: `cpu_wr_ready` is 0 in receive and while the next write buffer is full. `cpu_rd_valid` is 0 in transmit and while the next read buffer is not full. `cpu_rd_data` is stable while valid is high and ready is low.
- R12: A buffer's full flag is set from its 8th stored byte until its 8th byte has been consumed. Its empty flag is always the inverse of its full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx | input | 1 | Direction: 0 transmit, 1 receive |
| cfg_flow_en | input | 1 | Enables occupancy-based clock gating |
| cfg_xfer_en | input | 1 | Transfer enable; clock can start only while set |
| msk_we | input | 1 | Mask register write strobe |
| msk_wdata | input | 4 | Mask word ({empty1, empty0, full1, full0}) |
| cpu_wr_valid | input | 1 | Processor write byte valid |
| cpu_wr_ready | output | 1 | Block can accept a write byte |
| cpu_wr_data | input | 8 | Processor write byte |
| cpu_rd_valid | output | 1 | Received byte available |
| cpu_rd_ready | input | 1 | Processor accepts the read byte |
| cpu_rd_data | output | 8 | Received byte |
| bus_clk_en | output | 1 | Card bus clock enable, one bit per enabled cycle |
| bus_dout | output | 1 | Serial transmit bit |
| bus_din | input | 1 | Serial receive bit |
| flag_full | output | 2 | Per-buffer full flags |
| flag_empty | output | 2 | Per-buffer empty flags |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench first stalls each direction completely, with both buffers drained in transmit and both filled in receive. It then checks that the clock comes back only on the 8th processor access and not on the 7th. A design that restarted too early would drop or duplicate bytes, which the byte scoreboards catch. A design that never restarted would hang until the watchdog expires. Dropping the transfer enable in the middle of a byte shows whether the design splits bytes, because the total count of enabled cycles then stops being a multiple of 8. Running with flow control off and no data exposes a design that consumes stale buffer contents instead of sending the 0xFF idle pattern. The mask bit layout is probed one bit at a time, so swapped full and empty bits show up as a wrong `irq`.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CFC_NBUF = 2;
  localparam int CFC_SELW = 1;

  typedef logic [CFC_NBUF-1:0] bufvec_t;

  // Stop condition at a byte boundary: transmit starves when no buffer
  // holds a complete block, receive stalls when every buffer is full.
  function automatic logic cfc_stall(input logic is_rx, input bufvec_t full);
    return is_rx ? (&full) : ~(|full);
  endfunction
endpackage

// File: rtl/cfc_buffer.sv
module cfc_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              wr_last,
  output logic              rd_last
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr;
  logic [PW-1:0]     rptr;
  logic              full_q;

  assign wr_last = (wptr == TOP);
  assign rd_last = (rptr == TOP);
  assign full    = full_q;
  assign rd_data = mem[rptr];

  // A block fills completely, then drains completely; no mixing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_en && !full_q) begin
        wptr <= wr_last ? '0 : wptr + 1'b1;
        if (wr_last) full_q <= 1'b1;
      end
      if (rd_en && full_q) begin
        rptr <= rd_last ? '0 : rptr + 1'b1;
        if (rd_last) full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full_q) mem[wptr] <= wr_data;
  end
endmodule

// File: rtl/cfc_serial.sv
module cfc_serial #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              is_rx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              din,
  output logic              dout,
  output logic              boundary,
  output logic              tx_take,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     bit_pos;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;

  assign boundary = (bit_pos == '0);
  assign tx_take  = tick & boundary & ~is_rx;
  assign rx_done  = tick & (bit_pos == LAST) & is_rx;
  assign rx_byte  = {rx_sh, din};
  assign dout     = tx_sh[DATA_W-1];

  // Nothing moves without a tick, so the bus freezes when gated.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
    end else if (tick) begin
      bit_pos <= (bit_pos == LAST) ? '0 : bit_pos + 1'b1;
      if (is_rx)         rx_sh <= rx_byte[DATA_W-2:0];
      else if (boundary) tx_sh <= tx_byte;
      else               tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/cfc_gate.sv
module cfc_gate
  import cfc_pkg::*;
(
  input  logic    boundary,
  input  logic    xfer_en,
  input  logic    flow_en,
  input  logic    is_rx,
  input  bufvec_t full,
  output logic    clk_en
);
  logic stall;

  assign stall  = flow_en & cfc_stall(is_rx, full);
  // Mid-byte the clock always runs; decisions happen only between bytes.
  assign clk_en = ~boundary | (xfer_en & ~stall);
endmodule

// File: rtl/cfc_irq.sv
module cfc_irq
  import cfc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msk_we,
  input  logic [2*CFC_NBUF-1:0] msk_wdata,
  input  bufvec_t               full,
  input  bufvec_t               empty,
  output logic                  irq
);
  logic [2*CFC_NBUF-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '1;
    else if (msk_we) mask_q <= msk_wdata;
  end

  assign irq = |({empty, full} & ~mask_q);
endmodule

// File: rtl/card_flow_ctrl.sv
module card_flow_ctrl
  import cfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_rx,
  input  logic                  cfg_flow_en,
  input  logic                  cfg_xfer_en,
  input  logic                  msk_we,
  input  logic [2*CFC_NBUF-1:0] msk_wdata,
  input  logic                  cpu_wr_valid,
  output logic                  cpu_wr_ready,
  input  logic [DATA_W-1:0]     cpu_wr_data,
  output logic                  cpu_rd_valid,
  input  logic                  cpu_rd_ready,
  output logic [DATA_W-1:0]     cpu_rd_data,
  output logic                  bus_clk_en,
  output logic                  bus_dout,
  input  logic                  bus_din,
  output logic [CFC_NBUF-1:0]   flag_full,
  output logic [CFC_NBUF-1:0]   flag_empty,
  output logic                  irq
);
  bufvec_t             full, wr_last, rd_last, b_wr_en, b_rd_en;
  logic [DATA_W-1:0]   b_wdata;
  logic [DATA_W-1:0]   b_rdata [CFC_NBUF];
  logic [CFC_SELW-1:0] cpu_sel, ser_sel;

  logic              ser_boundary, tx_take, rx_done;
  logic [DATA_W-1:0] rx_byte, tx_byte;
  logic              cpu_wr_fire, cpu_rd_fire, tx_take_ok, rx_store;

  assign cpu_wr_ready = ~cfg_rx & ~full[cpu_sel];
  assign cpu_rd_valid =  cfg_rx &  full[cpu_sel];
  assign cpu_rd_data  = b_rdata[cpu_sel];
  assign cpu_wr_fire  = cpu_wr_valid & cpu_wr_ready;
  assign cpu_rd_fire  = cpu_rd_valid & cpu_rd_ready;

  // Underrun (flow off only): idle ones go out and nothing is consumed.
  assign tx_byte    = full[ser_sel] ? b_rdata[ser_sel] : '1;
  assign tx_take_ok = tx_take & full[ser_sel];
  // Overrun (flow off only): the completed byte is dropped.
  assign rx_store   = rx_done & ~full[ser_sel];
  assign b_wdata    = cfg_rx ? rx_byte : cpu_wr_data;

  for (genvar i = 0; i < CFC_NBUF; i++) begin : g_buf
    assign b_wr_en[i] = cfg_rx ? (rx_store    && ser_sel == CFC_SELW'(i))
                               : (cpu_wr_fire && cpu_sel == CFC_SELW'(i));
    assign b_rd_en[i] = cfg_rx ? (cpu_rd_fire && cpu_sel == CFC_SELW'(i))
                               : (tx_take_ok  && ser_sel == CFC_SELW'(i));

    cfc_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (b_wr_en[i]),
      .wr_data (b_wdata),
      .rd_en   (b_rd_en[i]),
      .rd_data (b_rdata[i]),
      .full    (full[i]),
      .wr_last (wr_last[i]),
      .rd_last (rd_last[i])
    );
  end

  // Both sides walk the buffers in the same alternating order.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_sel <= '0;
      ser_sel <= '0;
    end else begin
      if ((cpu_wr_fire && wr_last[cpu_sel]) || (cpu_rd_fire && rd_last[cpu_sel]))
        cpu_sel <= cpu_sel + 1'b1;
      if ((tx_take_ok && rd_last[ser_sel]) || (rx_store && wr_last[ser_sel]))
        ser_sel <= ser_sel + 1'b1;
    end
  end

  cfc_serial #(.DATA_W(DATA_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bus_clk_en),
    .is_rx    (cfg_rx),
    .tx_byte  (tx_byte),
    .din      (bus_din),
    .dout     (bus_dout),
    .boundary (ser_boundary),
    .tx_take  (tx_take),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte)
  );

  cfc_gate u_gate (
    .boundary (ser_boundary),
    .xfer_en  (cfg_xfer_en),
    .flow_en  (cfg_flow_en),
    .is_rx    (cfg_rx),
    .full     (full),
    .clk_en   (bus_clk_en)
  );

  assign flag_full  = full;
  assign flag_empty = ~full;

  cfc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .msk_we    (msk_we),
    .msk_wdata (msk_wdata),
    .full      (full),
    .empty     (flag_empty),
    .irq       (irq)
  );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rx,
  input logic              cfg_flow_en,
  input logic              cpu_wr_ready,
  input logic              cpu_rd_valid,
  input logic              cpu_rd_ready,
  input logic [DATA_W-1:0] cpu_rd_data,
  input logic              bus_clk_en,
  input logic              bus_dout,
  input logic [1:0]        flag_full,
  input logic              ser_boundary
);
  p_tx_starve_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_boundary && cfg_flow_en && !cfg_rx && flag_full == 2'b00) |-> !bus_clk_en);

  p_bus_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk_en |=> $stable(bus_dout));

  p_rx_fill_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_boundary && cfg_flow_en && cfg_rx && flag_full == 2'b11) |-> !bus_clk_en);

  p_no_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_boundary |-> bus_clk_en);

  p_wr_backpressure_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rx && flag_full == 2'b11) |-> !cpu_wr_ready);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rx && cpu_rd_valid && !cpu_rd_ready) |=> (cpu_rd_valid && $stable(cpu_rd_data)));
endmodule

bind card_flow_ctrl cfc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rx       (cfg_rx),
  .cfg_flow_en  (cfg_flow_en),
  .cpu_wr_ready (cpu_wr_ready),
  .cpu_rd_valid (cpu_rd_valid),
  .cpu_rd_ready (cpu_rd_ready),
  .cpu_rd_data  (cpu_rd_data),
  .bus_clk_en   (bus_clk_en),
  .bus_dout     (bus_dout),
  .flag_full    (flag_full),
  .ser_boundary (ser_boundary)
);

// File: tb/tb_card_flow_ctrl.sv
`timescale 1ns/100ps
module tb_card_flow_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rx = 1'b0, cfg_flow_en = 1'b0, cfg_xfer_en = 1'b0;
  logic msk_we = 1'b0;
  logic [3:0] msk_wdata = 4'hF;
  logic cpu_wr_valid = 1'b0, cpu_rd_ready = 1'b0, bus_din = 1'b1;
  logic [7:0] cpu_wr_data = 8'h00;
  logic cpu_wr_ready, cpu_rd_valid, bus_clk_en, bus_dout, irq;
  logic [7:0] cpu_rd_data;
  logic [1:0] flag_full, flag_empty;

  always #2.5 clk = ~clk;

  card_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_flow_en(cfg_flow_en),
    .cfg_xfer_en(cfg_xfer_en), .msk_we(msk_we), .msk_wdata(msk_wdata),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_valid(cpu_rd_valid), .cpu_rd_ready(cpu_rd_ready), .cpu_rd_data(cpu_rd_data),
    .bus_clk_en(bus_clk_en), .bus_dout(bus_dout), .bus_din(bus_din),
    .flag_full(flag_full), .flag_empty(flag_empty), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  int mon_mode = 0;   // 0 off, 1 scoreboard, 2 idle bytes expected
  int tick_count = 0;
  bit src_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'(n * 29) ^ 8'h5A;
  endfunction

  task automatic settle();
    @(negedge clk); #1.2;
  endtask

  // Transmit driver: pushes each accepted byte onto the scoreboard.
  task automatic cpu_write(input logic [7:0] b);
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_data = b;
    #1.2;
    while (!cpu_wr_ready) begin @(negedge clk); #1.2; end
    tx_q.push_back(b);
    @(posedge clk); #1 cpu_wr_valid = 1'b0;
  endtask

  // Receive consumer: compares each accepted byte with the scoreboard.
  task automatic cpu_read();
    logic [7:0] exp;
    @(negedge clk);
    cpu_rd_ready = 1'b1;
    #1.5;
    while (!cpu_rd_valid) begin @(negedge clk); #1.5; end
    if (rx_q.size() == 0) chk(1'b0, "R5 underflow", cpu_rd_data, 0);
    else begin
      exp = rx_q.pop_front();
      chk(cpu_rd_data == exp, "R5 rx byte", cpu_rd_data, exp);
    end
    @(posedge clk); #1 cpu_rd_ready = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); msk_we = 1'b1; msk_wdata = m;
    @(negedge clk); msk_we = 1'b0;
    #1.2;
  endtask

  // Transmit monitor: rebuilds bytes from bus_dout one enabled cycle at a time.
  initial begin
    bit pend = 0;
    int nb = 0;
    logic [7:0] cap = '0;
    logic [7:0] exp;
    forever begin
      @(negedge clk); #1;
      if (pend) begin
        cap = {cap[6:0], bus_dout};
        nb++;
        tick_count++;
        if (nb == 8) begin
          nb = 0;
          if (mon_mode == 1) begin
            if (tx_q.size() == 0) chk(1'b0, "R2 unexpected byte", cap, 0);
            else begin
              exp = tx_q.pop_front();
              chk(cap == exp, "R2 tx byte", cap, exp);
            end
          end else if (mon_mode == 2) begin
            chk(cap == 8'hFF, "R8 idle byte", cap, 8'hFF);
          end
        end
      end
      pend = bus_clk_en && !cfg_rx && rst_n;
    end
  end

  // Receive source: drives bus_din MSB first, logs each byte once delivered.
  initial begin
    bit spend = 0;
    int sbit = 0, sent = 0;
    logic [7:0] cur = pat(0);
    forever begin
      @(negedge clk); #1;
      if (spend) begin
        sbit++;
        if (sbit == 8) begin
          rx_q.push_back(cur);
          sent++;
          cur = pat(sent);
          sbit = 0;
        end
      end
      bus_din = cur[7 - sbit];
      spend = bus_clk_en && cfg_rx && src_on && rst_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int guard;
    logic [7:0] stream [8] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'h3C, 8'hC3};

    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    chk(bus_clk_en == 1'b0, "R1 clk_en", bus_clk_en, 0);
    chk(flag_empty == 2'b11, "R1 empty", flag_empty, 3);
    chk(flag_full == 2'b00, "R1 full", flag_full, 0);
    chk(irq == 1'b0, "R1 irq masked", irq, 0);
    chk(cpu_wr_ready == 1'b1 && cpu_rd_valid == 1'b0, "R1 handshake", {cpu_wr_ready, cpu_rd_valid}, 2);

    set_mask(4'b1011);
    chk(irq == 1'b1, "R10 empty0 unmasked", irq, 1);
    set_mask(4'b0111);
    chk(irq == 1'b1, "R10 empty1 unmasked", irq, 1);
    set_mask(4'b1110);
    chk(irq == 1'b0, "R10 full0 unmasked but clear", irq, 0);

    // Preload buffer 0 with the transfer disabled.
    cfg_flow_en = 1'b1;
    mon_mode = 1;
    for (int i = 0; i < 8; i++) cpu_write(stream[i]);
    settle();
    chk(flag_full == 2'b01, "R12 full after 8 writes", flag_full, 1);
    chk(flag_empty == 2'b10, "R12 empty complement", flag_empty, 2);
    chk(irq == 1'b1, "R10 full0 raises irq", irq, 1);
    chk(bus_clk_en == 1'b0, "R1 no clock without xfer", bus_clk_en, 0);
    set_mask(4'b1111);
    chk(irq == 1'b0, "R10 all masked", irq, 0);

    @(negedge clk) cfg_xfer_en = 1'b1;
    #1.2;
    chk(bus_clk_en == 1'b1, "R4 start with one full", bus_clk_en, 1);
    for (int i = 0; i < 8; i++) cpu_write(pat(100 + i));
    settle();
    chk(flag_full == 2'b11, "R12 both full", flag_full, 3);
    chk(cpu_wr_ready == 1'b0, "R11 write back-pressure", cpu_wr_ready, 0);
    for (int i = 0; i < 16; i++) cpu_write(stream[i % 8] ^ 8'(i));

    guard = 0;
    do begin settle(); guard++; end while (bus_clk_en && guard < 3000);
    chk(tx_q.size() == 0, "R2 all bytes sent", tx_q.size(), 0);
    chk(flag_empty == 2'b11, "R3 both empty at stop", flag_empty, 3);
    held = {7'd0, bus_dout};
    for (int i = 0; i < 16; i++) begin
      settle();
      if (bus_clk_en || bus_dout != held[0]) chk(1'b0, "R3 frozen", {bus_clk_en, bus_dout}, {1'b0, held[0]});
    end
    chk(bus_clk_en == 1'b0, "R3 stays stopped", bus_clk_en, 0);

    for (int i = 0; i < 7; i++) cpu_write(pat(200 + i));
    settle();
    chk(bus_clk_en == 1'b0, "R4 seven writes not enough", bus_clk_en, 0);
    cpu_write(pat(207));
    settle();
    chk(bus_clk_en == 1'b1, "R4 restart on 8th write", bus_clk_en, 1);
    guard = 0;
    do begin settle(); guard++; end while (bus_clk_en && guard < 3000);
    chk(tx_q.size() == 0, "R2 restart block sent", tx_q.size(), 0);

    // Flow control off with nothing buffered.
    @(negedge clk);
    mon_mode = 2; cfg_flow_en = 1'b0; tick_count = 0; cfg_xfer_en = 1'b1;
    #1.2;
    chk(bus_clk_en == 1'b1, "R8 clock runs while empty", bus_clk_en, 1);
    repeat (20) @(negedge clk);
    cfg_xfer_en = 1'b0;
    #1.2;
    if (tick_count % 8 != 0) chk(bus_clk_en == 1'b1, "R9 mid-byte continues", bus_clk_en, 1);
    repeat (12) settle();
    chk(tick_count % 8 == 0 && tick_count >= 8, "R9 whole bytes", tick_count, 24);
    chk(bus_clk_en == 1'b0, "R9 stopped after byte", bus_clk_en, 0);
    chk(flag_empty == 2'b11, "R8 nothing consumed", flag_empty, 3);

    // Receive direction.
    @(negedge clk);
    mon_mode = 0; rst_n = 1'b0; cfg_rx = 1'b1; cfg_flow_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk(cpu_rd_valid == 1'b0, "R11 no read data", cpu_rd_valid, 0);
    chk(cpu_wr_ready == 1'b0, "R11 no write in rx", cpu_wr_ready, 0);
    @(negedge clk) begin src_on = 1; cfg_xfer_en = 1'b1; end
    #1.2;
    chk(bus_clk_en == 1'b1, "R5 rx clock runs", bus_clk_en, 1);
    guard = 0;
    do begin settle(); guard++; end while (bus_clk_en && guard < 3000);
    chk(rx_q.size() == 16, "R6 stop after 16 bytes", rx_q.size(), 16);
    chk(flag_full == 2'b11, "R6 both full", flag_full, 3);
    repeat (10) settle();
    chk(bus_clk_en == 1'b0, "R6 stays stopped", bus_clk_en, 0);
    chk(cpu_rd_valid == 1'b1, "R11 read data offered", cpu_rd_valid, 1);

    for (int i = 0; i < 7; i++) cpu_read();
    settle();
    chk(bus_clk_en == 1'b0, "R7 seven reads not enough", bus_clk_en, 0);
    cpu_read();
    settle();
    chk(bus_clk_en == 1'b1, "R7 restart on 8th read", bus_clk_en, 1);
    for (int i = 0; i < 40; i++) cpu_read();
    @(negedge clk) cfg_xfer_en = 1'b0;
    repeat (4) settle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule